// File: doc/BRIEF.md
# Fixed-Point Compare and Trap Unit

A purely combinational unit that orders two 64-bit integer operands and turns the result into one of two things. For a compare instruction it yields a condition field: less, greater or equal, with the current summary-overflow bit copied in. For a trap instruction it yields a single trap-request flag, formed from a 5-bit mask of enabled conditions.

The second operand is either a register or a 16-bit immediate. A width select picks between word forms, which use only the low 32 bits of each register, and doubleword forms, which use the full 64 bits.

A compare can be signed or logical. The width and signedness select how the low half and the immediate are extended to 64 bits. One set of comparators (signed less, unsigned less, equal) serves both instruction classes. Writing the condition register and raising the trap interrupt are left to the surrounding pipeline.

Top module: `cmp_trap_unit`

## Requirements
- R1: A signed word compare (`dword`=0, `logical`=0) sign-extends bit 31 of each register operand, so bits 63:32 of `opa` and `opb` have no effect on the result.
- R2: With `dword`=1, all 64 bits of each register operand take part in the comparison.
- R3: With `use_imm`=1 on a signed compare, the second operand is `imm` sign-extended from bit 15 to 64 bits.
- R4: A logical compare (`logical`=1) orders the operands as unsigned numbers. Word forms zero-extend the low 32 bits of each register, and the immediate is zero-extended from 16 bits.
- R5: For a compare (`is_trap`=0), `crf[3:1]` is 3'b100 when the first operand is smaller, 3'b010 when it is larger and 3'b001 when the two are equal, so exactly one of the three bits is set.
- R6: For a compare, `crf[0]` equals `so_in`.
- R7: For a trap (`is_trap`=1), word forms sign-extend the low 32 bits of both register operands, and doubleword forms use the full registers. The immediate is always sign-extended from 16 bits, and `logical` has no effect.
- R8: For a trap, `trap_req` is the OR of the enabled conditions. The mask bits are: `to_mask[0]` signed less, `to_mask[1]` signed greater, `to_mask[2]` equal, `to_mask[3]` unsigned less, `to_mask[4]` unsigned greater. A mask of all ones always traps.
- R9: `trap_req` is 0 for every compare, and for a trap whose mask is zero. `crf` is 4'b0000 for every trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 64 | First register operand |
| opb | input | 64 | Second register operand |
| imm | input | 16 | Immediate second operand |
| use_imm | input | 1 | 1 selects `imm` instead of `opb` |
| dword | input | 1 | 1 selects doubleword form, 0 selects word form |
| logical | input | 1 | 1 selects unsigned compare (ignored for traps) |
| is_trap | input | 1 | 0 selects compare, 1 selects trap |
| to_mask | input | 5 | Trap condition enables |
| so_in | input | 1 | Current summary-overflow bit |
| crf | output | 4 | Condition field {less, greater, equal, so} |
| trap_req | output | 1 | Trap request |

## Verification
The bench drives operands on both sides of the 32-bit and 64-bit sign boundaries (0x7FFF_FFFF against 0x8000_0000, and their 64-bit counterparts). A unit that extended the wrong half, or treated a signed compare as unsigned, would report greater where less is correct.

It places garbage in the upper halves of word operands; a unit that leaked those bits would not report equal. It also uses immediates with bit 15 set, so a unit that zero-extended a signed immediate, or sign-extended a logical one, would flip the ordering.

For traps, each mask bit is tested alone on operands whose signed and unsigned orderings disagree. This exposes a swapped or misnumbered mask bit. It also exposes a trap that honoured the logical select.

// File: rtl/cmp_trap_unit.sv
module cmp_trap_unit #(
  parameter int XLEN = 64,
  parameter int HALF = 32,
  parameter int IMMW = 16,
  parameter int TOW  = 5
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [IMMW-1:0] imm,
  input  logic            use_imm,
  input  logic            dword,
  input  logic            logical,
  input  logic            is_trap,
  input  logic [TOW-1:0]  to_mask,
  input  logic            so_in,
  output logic [3:0]      crf,
  output logic            trap_req
);

  logic            sx;
  logic [XLEN-1:0] a_op, b_reg, b_imm, b_op;
  logic            s_lt, u_lt, eq, s_gt, u_gt;
  logic            lt, gt;
  logic [TOW-1:0]  hits;

  assign sx = is_trap | ~logical;

  assign a_op  = dword ? opa : {{(XLEN-HALF){sx & opa[HALF-1]}}, opa[HALF-1:0]};
  assign b_reg = dword ? opb : {{(XLEN-HALF){sx & opb[HALF-1]}}, opb[HALF-1:0]};
  assign b_imm = {{(XLEN-IMMW){sx & imm[IMMW-1]}}, imm};
  assign b_op  = use_imm ? b_imm : b_reg;

  assign eq   = (a_op == b_op);
  assign u_lt = (a_op < b_op);
  assign s_lt = (a_op[XLEN-1] != b_op[XLEN-1]) ? a_op[XLEN-1] : u_lt;
  assign s_gt = ~s_lt & ~eq;
  assign u_gt = ~u_lt & ~eq;

  assign lt = logical ? u_lt : s_lt;
  assign gt = logical ? u_gt : s_gt;

  assign hits = {u_gt, u_lt, eq, s_gt, s_lt} & to_mask;

  assign crf      = is_trap ? 4'b0000 : {lt, gt, eq, so_in};
  assign trap_req = is_trap & (|hits);

endmodule

module cmp_trap_unit_chk (
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic        use_imm,
  input logic        dword,
  input logic        logical,
  input logic        is_trap,
  input logic [4:0]  to_mask,
  input logic        so_in,
  input logic [3:0]  crf,
  input logic        trap_req
);
  always_comb begin
    a_r5_one_hot: assert (is_trap || $countones(crf[3:1]) == 1);
    a_r6_so_copy: assert (is_trap || crf[0] == so_in);
    a_r9_no_trap_on_cmp: assert (is_trap || !trap_req);
    a_r9_zero_field_on_trap: assert (!is_trap || crf == 4'b0000);
    a_r9_empty_mask: assert (!(is_trap && to_mask == 5'b0) || !trap_req);
    a_r8_full_mask: assert (!(is_trap && to_mask == 5'b11111) || trap_req);
    a_r2_dword_eq: assert (!(!is_trap && dword && !use_imm && opa == opb) || crf[1]);
    a_r2_dword_signed: assert (!(!is_trap && dword && !use_imm && !logical)
                               || crf[3] == ($signed(opa) < $signed(opb)));
  end
endmodule

bind cmp_trap_unit cmp_trap_unit_chk u_chk (
  .opa(opa), .opb(opb), .use_imm(use_imm), .dword(dword), .logical(logical),
  .is_trap(is_trap), .to_mask(to_mask), .so_in(so_in), .crf(crf), .trap_req(trap_req)
);

// File: tb/cmp_trap_unit_test.sv
module cmp_trap_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [63:0] opa, opb;
  logic [15:0] imm;
  logic use_imm, dword, logical, is_trap, so_in;
  logic [4:0] to_mask;
  logic [3:0] crf;
  logic trap_req;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  cmp_trap_unit uut (
    .opa(opa), .opb(opb), .imm(imm), .use_imm(use_imm), .dword(dword),
    .logical(logical), .is_trap(is_trap), .to_mask(to_mask), .so_in(so_in),
    .crf(crf), .trap_req(trap_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [15:0] i,
                       input logic ui, input logic dw, input logic lg, input logic tr,
                       input logic [4:0] tm, input logic so);
    opa = a; opb = b; imm = i; use_imm = ui; dword = dw;
    logical = lg; is_trap = tr; to_mask = tm; so_in = so;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [3:0] ecrf, input logic etrap);
    checks = checks + 1;
    if (crf !== ecrf || trap_req !== etrap) begin
      errors = errors + 1;
      $display("FAIL %s actual crf=%b trap=%b expected crf=%b trap=%b",
               req, crf, trap_req, ecrf, etrap);
    end
  endtask

  function automatic logic [3:0] ref_cmp(input logic [63:0] a, input logic [63:0] b,
                                         input logic dw, input logic lg);
    longint sa, sb;
    longint unsigned ua, ub;
    logic l, g;
    if (dw) begin
      sa = a; sb = b; ua = a; ub = b;
    end else begin
      sa = longint'(int'(a[31:0])); sb = longint'(int'(b[31:0]));
      ua = {32'd0, a[31:0]}; ub = {32'd0, b[31:0]};
    end
    l = lg ? (ua < ub) : (sa < sb);
    g = lg ? (ua > ub) : (sa > sb);
    return {l, g, !(l || g), 1'b0};
  endfunction

  task automatic t_idle;
    drive(64'd0, 64'd0, 16'd0, 0, 0, 0, 0, 5'd0, 0);
    expect_out("R5 idle equal", 4'b0010, 1'b0);
  endtask

  task automatic t_word_signed;
    drive(64'hFFFF_FFFF_8000_0000, 64'h0000_0000_7FFF_FFFF, 16'd0, 0, 0, 0, 0, 5'd0, 0);
    expect_out("R1 word sign boundary", 4'b1000, 1'b0);
    drive(64'h1234_5678_0000_0005, 64'h0000_0000_0000_0005, 16'd0, 0, 0, 0, 0, 5'd0, 0);
    expect_out("R1 upper half ignored", 4'b0010, 1'b0);
  endtask

  task automatic t_dword_signed;
    drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 16'd0, 0, 1, 0, 0, 5'd0, 0);
    expect_out("R2 dword positive", 4'b0100, 1'b0);
    drive(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 16'd0, 0, 1, 0, 0, 5'd0, 0);
    expect_out("R2 dword sign boundary", 4'b1000, 1'b0);
  endtask

  task automatic t_logical;
    drive(64'hFFFF_FFFF_8000_0000, 64'h0000_0000_7FFF_FFFF, 16'd0, 0, 0, 1, 0, 5'd0, 0);
    expect_out("R4 word unsigned", 4'b0100, 1'b0);
    drive(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 16'd0, 0, 1, 1, 0, 5'd0, 0);
    expect_out("R4 dword unsigned", 4'b0100, 1'b0);
    drive(64'h0000_0000_0000_8000, 64'd0, 16'h8000, 1, 1, 1, 0, 5'd0, 0);
    expect_out("R4 imm zero-extended equal", 4'b0010, 1'b0);
    drive(64'hFFFF_FFFF_FFFF_8000, 64'd0, 16'h8000, 1, 1, 1, 0, 5'd0, 0);
    expect_out("R4 imm zero-extended greater", 4'b0100, 1'b0);
  endtask

  task automatic t_imm_signed;
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'hFFFF, 1, 1, 0, 0, 5'd0, 0);
    expect_out("R3 imm minus one", 4'b0010, 1'b0);
    drive(64'd0, 64'd0, 16'h8000, 1, 1, 0, 0, 5'd0, 0);
    expect_out("R3 imm most negative", 4'b0100, 1'b0);
    drive(64'h1111_1111_FFFF_8000, 64'd0, 16'h8000, 1, 0, 0, 0, 5'd0, 0);
    expect_out("R3 word imm equal", 4'b0010, 1'b0);
  endtask

  task automatic t_so;
    drive(64'd7, 64'd7, 16'd0, 0, 1, 0, 0, 5'd0, 1);
    expect_out("R6 so copied", 4'b0011, 1'b0);
    drive(64'd3, 64'd7, 16'd0, 0, 1, 1, 0, 5'd0, 1);
    expect_out("R6 so with less", 4'b1001, 1'b0);
  endtask

  task automatic t_trap;
    drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 16'd0, 0, 0, 0, 1, 5'b00001, 1);
    expect_out("R8 word signed less", 4'b0000, 1'b1);
    drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 16'd0, 0, 0, 0, 1, 5'b00010, 0);
    expect_out("R7 word sign-extended not greater", 4'b0000, 1'b0);
    drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 16'd0, 0, 0, 1, 1, 5'b01000, 0);
    expect_out("R7 logical ignored, not unsigned less", 4'b0000, 1'b0);
    drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 16'd0, 0, 0, 1, 1, 5'b10000, 0);
    expect_out("R8 unsigned greater", 4'b0000, 1'b1);
    drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 16'd0, 0, 1, 0, 1, 5'b00001, 0);
    expect_out("R7 dword not less", 4'b0000, 1'b0);
    drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 16'd0, 0, 1, 0, 1, 5'b00010, 0);
    expect_out("R7 dword signed greater", 4'b0000, 1'b1);
    drive(64'd5, 64'd0, 16'hFFFF, 1, 1, 0, 1, 5'b01000, 0);
    expect_out("R7 imm sign-extended unsigned less", 4'b0000, 1'b1);
    drive(64'd5, 64'd0, 16'hFFFF, 1, 1, 0, 1, 5'b00001, 0);
    expect_out("R8 imm not signed less", 4'b0000, 1'b0);
    drive(64'd9, 64'd9, 16'd0, 0, 1, 0, 1, 5'b00100, 0);
    expect_out("R8 equal", 4'b0000, 1'b1);
    drive(64'd9, 64'd9, 16'd0, 0, 1, 0, 1, 5'b11011, 0);
    expect_out("R8 equal masked off", 4'b0000, 1'b0);
    drive(64'd1, 64'd9, 16'd0, 0, 1, 0, 1, 5'b00000, 0);
    expect_out("R9 empty mask", 4'b0000, 1'b0);
    drive(64'd1, 64'd9, 16'd0, 0, 1, 0, 0, 5'b11111, 0);
    expect_out("R9 compare never traps", 4'b1000, 1'b0);
  endtask

  task automatic t_sweep;
    logic [63:0] pts [8];
    pts[0] = 64'h0; pts[1] = 64'h1; pts[2] = 64'h0000_0000_7FFF_FFFF;
    pts[3] = 64'h0000_0000_8000_0000; pts[4] = 64'hFFFF_FFFF_8000_0000;
    pts[5] = 64'h7FFF_FFFF_FFFF_FFFF; pts[6] = 64'h8000_0000_0000_0000;
    pts[7] = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 4; m++) begin
          drive(pts[i], pts[j], 16'd0, 0, m[0], m[1], 0, 5'd0, 0);
          expect_out("R5 boundary sweep", ref_cmp(pts[i], pts[j], m[0], m[1]), 1'b0);
        end
  endtask

  initial begin
    opa = '0; opb = '0; imm = '0; use_imm = 0; dword = 0;
    logical = 0; is_trap = 0; to_mask = '0; so_in = 0;
    @(negedge clk);
    t_idle;
    t_word_signed;
    t_dword_signed;
    t_logical;
    t_imm_signed;
    t_so;
    t_trap;
    t_sweep;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule